// File: doc/BRIEF.md
# Two-Stage Countdown Watchdog with Byte-Addressed Registers

The block is a watchdog timer placed behind a small register bank that software reaches through a little-endian bus taking 1- and 2-byte accesses. A down-counter advances once for each pulse of a tick enable. Each time the counter runs out, the block sets a timeout status bit and keeps a one-bit record of how many times it has run out. On the first expiry it can raise an SMI request and then reload itself from the programmed timer value. On the second expiry it also sets two status bits. It then asks for a platform reset and halts, unless a speaker strap input or a no-reboot input blocks the reboot. When the reboot is blocked, the second expiry behaves like the first.

Software keeps the watchdog alive by writing the reload register. It can halt the counter through a control bit. It can set a lock bit that stays at 1 until the block is reset. The bank also holds two data bytes: writing the incoming one raises an SMI, and writing the outgoing one raises a status interrupt flag. It further holds message and scratch bytes, a second control register and a software-interrupt byte. The reset request and the SMI request are single-cycle pulses. Bus reads are combinational.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, the second control word reads 0x0008, the timer word reads 0x0004 and the software-interrupt byte reads 0x03. Every other register reads 0, the counter is stopped, and smi_req, reset_req and status_irq are low.
- R2: The counter may start only while halt bit 11 of the first control word is 0 and the 10-bit timer value (bits [9:0] of the timer word, upper bits read 0) is above 1. With a timer value of 0 or 1, a reload write only stores the written word and ticks change nothing.
- R3: Any write to the reload word clears the timeout record. If the counter may start, the reload word takes the timer value and counting begins. Otherwise the merged written word is stored.
- R4: While running, each tick lowers reload bits [9:0] by one, and a read of the reload word returns that live count. A tick arriving at a count of 1 (or 0) is an expiry, which sets timeout bit 3 of the first status word.
- R5: On an expiry while the timeout record is already set, bits 1 and 2 of the second status word are set and the record clears. If strap_spkr_hi and no_reboot are both low, reset_req pulses for one cycle, the reload word becomes 0 and the counter stops, with no SMI.
- R6: Every expiry that does not request a reset pulses smi_req for one cycle when smi_enable is high. It then reloads the count from the timer value and keeps running.
- R7: A write to the data-in byte stores it, sets bit 1 of the first status word and pulses smi_req whatever smi_enable is. A write to the data-out byte stores it and sets bit 2. status_irq always equals bit 2 of the first status word.
- R8: Writes to the first control word keep only bits [12:8]. Lock bit 12 cannot return to 0 by a write. After the write the counter restarts from the timer value if it may run, and stops otherwise.
- R9: A write to the first status word stores the data ANDed with 0x000E. A write to the second status word stores the data ANDed with 0x0006.
- R10: The byte map is: reload 0x00, data-in 0x02, data-out 0x03, status-1 0x04, status-2 0x06, control-1 0x08, control-2 0x0A, message-1 0x0C, message-2 0x0D, watchdog-count 0x0E, software-interrupt 0x0F, timer 0x10. A byte access at an odd address reaches bits [15:8] of the pair, and that byte is returned on bus_rdata[7:0]. A 2-byte access at an odd address, and any access from 0x12 upward, reads 0 and writes nothing.
- R11: A tick that arrives in the same cycle as an accepted register write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (5) | Byte address of the access |
| bus_half | input | 1 | 1 selects a 2-byte access, 0 a 1-byte access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data; byte accesses use bits [7:0] |
| bus_rdata | output | 16 | Combinational read data for the current address |
| tick_en | input | 1 | One-cycle count enable |
| strap_spkr_hi | input | 1 | Speaker strap; high blocks the reboot |
| no_reboot | input | 1 | Configuration bit; high blocks the reboot |
| smi_enable | input | 1 | Allows expiry SMI requests |
| smi_req | output | 1 | One-cycle SMI request |
| reset_req | output | 1 | One-cycle platform reset request |
| status_irq | output | 1 | Mirror of the data-out status bit |

## Verification
The bench steps the counter through both expiry stages under each combination of strap, no-reboot and SMI enable. A design that miscounted the timeout record would reset on the first expiry, or never reset at all. A design that ignored the blocking inputs would reset when it should not. Timer values of 0 and 1, halting, and ticks that coincide with writes are exercised, so that a wrongly started counter or a tick that is not dropped shows up in a reload readback. Lane steering, odd 2-byte accesses, unmapped addresses, the writable masks and the sticky lock are each read back after being written. A mistake in any of them gives a wrong byte or a bit that should have been masked.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int NSLOT  = 9;
    localparam int SLOT_W = 4;

    // 16-bit slots; slot n covers byte addresses 2n and 2n+1
    localparam logic [SLOT_W-1:0] S_RLD  = 4'd0;
    localparam logic [SLOT_W-1:0] S_DATA = 4'd1;
    localparam logic [SLOT_W-1:0] S_STS1 = 4'd2;
    localparam logic [SLOT_W-1:0] S_STS2 = 4'd3;
    localparam logic [SLOT_W-1:0] S_CTL1 = 4'd4;
    localparam logic [SLOT_W-1:0] S_CTL2 = 4'd5;
    localparam logic [SLOT_W-1:0] S_MSG  = 4'd6;
    localparam logic [SLOT_W-1:0] S_AUX  = 4'd7;
    localparam logic [SLOT_W-1:0] S_TMR  = 4'd8;

    localparam int ST1_SWSMI  = 1;
    localparam int ST1_INT    = 2;
    localparam int ST1_TO     = 3;
    localparam int ST2_SECOND = 1;
    localparam int ST2_BOOT   = 2;
    localparam int CTL1_HALT  = 11;
    localparam int CTL1_LOCK  = 12;

    localparam logic [15:0] STS1_WMASK = 16'h000E;
    localparam logic [15:0] STS2_WMASK = 16'h0006;
    localparam logic [15:0] CTL1_WMASK = 16'h1F00;

    localparam logic [15:0] CTL2_INIT  = 16'h0008;
    localparam logic [15:0] TMR_INIT   = 16'h0004;
    localparam logic [7:0]  SWIRQ_INIT = 8'h03;

    typedef struct packed {
        logic              valid;
        logic [SLOT_W-1:0] slot;
        logic [1:0]        lanes;
        logic [15:0]       data;
    } bus_req_t;

    typedef struct packed {
        logic [15:0] rld;
        logic [7:0]  din;
        logic [7:0]  dout;
        logic [15:0] sts1;
        logic [15:0] sts2;
        logic [15:0] ctl1;
        logic [15:0] ctl2;
        logic [7:0]  msg1;
        logic [7:0]  msg2;
        logic [7:0]  wdcnt;
        logic [7:0]  swirq;
        logic [15:0] tmr;
        logic        running;
        logic        once_expired;
    } wdg_regs_t;

    function automatic logic [15:0] merge_lanes(input logic [15:0] old_v,
                                                input logic [15:0] new_v,
                                                input logic [1:0]  lanes);
        logic [15:0] r;
        r[7:0]  = lanes[0] ? new_v[7:0]  : old_v[7:0];
        r[15:8] = lanes[1] ? new_v[15:8] : old_v[15:8];
        return r;
    endfunction

    function automatic logic may_run(input logic [15:0] ctl, input logic [15:0] tmr_field);
        return !ctl[CTL1_HALT] && (tmr_field > 16'd1);
    endfunction

endpackage

// File: rtl/wdg_bus_port.sv
module wdg_bus_port
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       half,
    input  logic                       wr,
    input  logic [15:0]                wdata,
    input  logic [NSLOT-1:0][15:0]     view,
    output bus_req_t                   req,
    output logic [15:0]                rdata
);
    localparam int IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0] idx;
    logic             hit;
    logic [15:0]      word;

    assign idx  = addr[ADDR_W-1:1];
    assign hit  = (int'(idx) < NSLOT) && !(half && addr[0]);
    assign word = hit ? view[SLOT_W'(idx)] : 16'h0000;

    always_comb begin
        req.valid = wr && hit;
        req.slot  = SLOT_W'(idx);
        if (half) begin
            req.lanes = 2'b11;
            req.data  = wdata;
        end else if (addr[0]) begin
            req.lanes = 2'b10;
            req.data  = {wdata[7:0], 8'h00};
        end else begin
            req.lanes = 2'b01;
            req.data  = {8'h00, wdata[7:0]};
        end
    end

    always_comb begin
        if (half)         rdata = word;
        else if (addr[0]) rdata = {8'h00, word[15:8]};
        else              rdata = {8'h00, word[7:0]};
    end

endmodule

// File: rtl/wdg_engine.sv
module wdg_engine
    import wdg_pkg::*;
#(
    parameter int TMR_W = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  bus_req_t               req,
    input  logic                   tick_en,
    input  logic                   strap_spkr_hi,
    input  logic                   no_reboot,
    input  logic                   smi_enable,
    output logic [NSLOT-1:0][15:0] view,
    output logic                   smi_req,
    output logic                   reset_req,
    output logic                   status_irq
);
    localparam logic [15:0] TMR_MASK = 16'((32'd1 << TMR_W) - 32'd1);

    wdg_regs_t   cur, nxt;
    logic        smi_n, rst_n;
    logic [15:0] mrg, ctl_new, cnt;

    always_comb begin
        view         = '0;
        view[S_RLD]  = cur.rld;
        view[S_DATA] = {cur.dout, cur.din};
        view[S_STS1] = cur.sts1;
        view[S_STS2] = cur.sts2;
        view[S_CTL1] = cur.ctl1;
        view[S_CTL2] = cur.ctl2;
        view[S_MSG]  = {cur.msg2, cur.msg1};
        view[S_AUX]  = {cur.swirq, cur.wdcnt};
        view[S_TMR]  = cur.tmr;
    end

    assign mrg     = merge_lanes(view[req.slot], req.data, req.lanes);
    assign ctl_new = (mrg & CTL1_WMASK) | (cur.ctl1 & (16'h1 << CTL1_LOCK));
    assign cnt     = cur.rld & TMR_MASK;

    always_comb begin
        nxt   = cur;
        smi_n = 1'b0;
        rst_n = 1'b0;
        if (req.valid) begin
            case (req.slot)
                S_RLD: begin
                    nxt.once_expired = 1'b0;
                    if (may_run(cur.ctl1, cur.tmr)) begin
                        nxt.rld     = cur.tmr;
                        nxt.running = 1'b1;
                    end else begin
                        nxt.rld = mrg;
                    end
                end
                S_DATA: begin
                    if (req.lanes[0]) begin
                        nxt.din             = mrg[7:0];
                        nxt.sts1[ST1_SWSMI] = 1'b1;
                        smi_n               = 1'b1;
                    end
                    if (req.lanes[1]) begin
                        nxt.dout          = mrg[15:8];
                        nxt.sts1[ST1_INT] = 1'b1;
                    end
                end
                S_STS1: nxt.sts1 = mrg & STS1_WMASK;
                S_STS2: nxt.sts2 = mrg & STS2_WMASK;
                S_CTL1: begin
                    nxt.ctl1 = ctl_new;
                    if (may_run(ctl_new, cur.tmr)) begin
                        nxt.rld     = cur.tmr;
                        nxt.running = 1'b1;
                    end else begin
                        nxt.running = 1'b0;
                    end
                end
                S_CTL2: nxt.ctl2 = mrg;
                S_MSG: begin
                    nxt.msg1 = mrg[7:0];
                    nxt.msg2 = mrg[15:8];
                end
                S_AUX: begin
                    nxt.wdcnt = mrg[7:0];
                    nxt.swirq = mrg[15:8];
                end
                S_TMR:   nxt.tmr = mrg & TMR_MASK;
                default: ;
            endcase
        end else if (tick_en && cur.running) begin
            if (cnt > 16'd1) begin
                nxt.rld = (cur.rld & ~TMR_MASK) | ((cnt - 16'd1) & TMR_MASK);
            end else begin
                nxt.sts1[ST1_TO] = 1'b1;
                if (cur.once_expired) begin
                    nxt.sts2[ST2_SECOND] = 1'b1;
                    nxt.sts2[ST2_BOOT]   = 1'b1;
                    nxt.once_expired     = 1'b0;
                end else begin
                    nxt.once_expired = 1'b1;
                end
                if (cur.once_expired && !strap_spkr_hi && !no_reboot) begin
                    nxt.rld     = 16'h0000;
                    nxt.running = 1'b0;
                    rst_n       = 1'b1;
                end else begin
                    smi_n   = smi_enable;
                    nxt.rld = cur.tmr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= '0;
            cur.ctl2  <= CTL2_INIT;
            cur.tmr   <= TMR_INIT;
            cur.swirq <= SWIRQ_INIT;
            smi_req   <= 1'b0;
            reset_req <= 1'b0;
        end else begin
            cur       <= nxt;
            smi_req   <= smi_n;
            reset_req <= rst_n;
        end
    end

    assign status_irq = cur.sts1[ST1_INT];

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int TMR_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_half,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              tick_en,
    input  logic              strap_spkr_hi,
    input  logic              no_reboot,
    input  logic              smi_enable,
    output logic              smi_req,
    output logic              reset_req,
    output logic              status_irq
);
    bus_req_t               req;
    logic [NSLOT-1:0][15:0] slot_view;

    wdg_bus_port #(.ADDR_W(ADDR_W)) u_port (
        .addr  (bus_addr),
        .half  (bus_half),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .view  (slot_view),
        .req   (req),
        .rdata (bus_rdata)
    );

    wdg_engine #(.TMR_W(TMR_W)) u_engine (
        .clk           (clk),
        .rst           (rst),
        .req           (req),
        .tick_en       (tick_en),
        .strap_spkr_hi (strap_spkr_hi),
        .no_reboot     (no_reboot),
        .smi_enable    (smi_enable),
        .view          (slot_view),
        .smi_req       (smi_req),
        .reset_req     (reset_req),
        .status_irq    (status_irq)
    );

endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
    parameter int TMR_W = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic        strap_spkr_hi,
    input logic        no_reboot,
    input logic        smi_req,
    input logic        reset_req,
    input logic        status_irq,
    input logic [15:0] ctl1_word,
    input logic [15:0] rld_word
);
    // R5
    no_dual_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(smi_req && reset_req));

    // R5
    reset_single_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    // R5
    reset_block_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> (!$past(strap_spkr_hi) && !$past(no_reboot)));

    // R5
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> (rld_word[TMR_W-1:0] == '0));

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctl1_word[12] |=> ctl1_word[12]);

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status_irq) |-> $past(bus_wr));

endmodule

bind tick_watchdog wdg_chk #(.TMR_W(TMR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_wr        (bus_wr),
    .strap_spkr_hi (strap_spkr_hi),
    .no_reboot     (no_reboot),
    .smi_req       (smi_req),
    .reset_req     (reset_req),
    .status_irq    (status_irq),
    .ctl1_word     (slot_view[wdg_pkg::S_CTL1]),
    .rld_word      (slot_view[wdg_pkg::S_RLD])
);

// File: tb/sim_tick_watchdog.sv
module sim_tick_watchdog;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_half = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        strap_spkr_hi = 1'b0;
    logic        no_reboot = 1'b0;
    logic        smi_enable = 1'b0;
    logic        smi_req, reset_req, status_irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    tick_watchdog u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_half(bus_half),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .strap_spkr_hi(strap_spkr_hi), .no_reboot(no_reboot),
        .smi_enable(smi_enable), .smi_req(smi_req), .reset_req(reset_req),
        .status_irq(status_irq)
    );

    // behavioural reference
    int m_rld, m_din, m_dout, m_s1, m_s2, m_c1, m_c2, m_m1, m_m2, m_wc, m_sw, m_tmr;
    int m_run, m_to, m_smi, m_rst;

    function automatic int m_word(input int base);
        case (base)
            0:  return m_rld;
            2:  return (m_dout << 8) | m_din;
            4:  return m_s1;
            6:  return m_s2;
            8:  return m_c1;
            10: return m_c2;
            12: return (m_m2 << 8) | m_m1;
            14: return (m_sw << 8) | m_wc;
            16: return m_tmr;
            default: return 0;
        endcase
    endfunction

    function automatic int m_read(input int a, input bit h);
        int v;
        if (h && (a % 2 == 1)) return 0;
        v = m_word(a - (a % 2));
        if (h) return v;
        return (a % 2 == 1) ? ((v >> 8) & 255) : (v & 255);
    endfunction

    function automatic bit m_ok(input int c, input int t);
        return ((c & 'h0800) == 0) && (t > 1);
    endfunction

    always @(posedge clk) begin
        int a, base, nv, c;
        bit lo, hi;
        if (rst) begin
            m_rld = 0; m_din = 0; m_dout = 0; m_s1 = 0; m_s2 = 0; m_c1 = 0;
            m_c2 = 8; m_m1 = 0; m_m2 = 0; m_wc = 0; m_sw = 3; m_tmr = 4;
            m_run = 0; m_to = 0; m_smi = 0; m_rst = 0;
        end else begin
            m_smi = 0; m_rst = 0;
            a = int'(bus_addr);
            if (bus_wr && !(bus_half && a % 2 == 1) && a < 18) begin
                base = a - (a % 2);
                lo = bus_half || (a % 2 == 0);
                hi = bus_half || (a % 2 == 1);
                nv = m_word(base);
                if (bus_half) nv = int'(bus_wdata);
                else if (hi) nv = (nv & 255) | (int'(bus_wdata[7:0]) << 8);
                else nv = (nv & 'hFF00) | int'(bus_wdata[7:0]);
                case (base)
                    0: begin
                        m_to = 0;
                        if (m_ok(m_c1, m_tmr)) begin m_rld = m_tmr; m_run = 1; end
                        else m_rld = nv;
                    end
                    2: begin
                        if (lo) begin m_din = nv & 255; m_s1 = m_s1 | 2; m_smi = 1; end
                        if (hi) begin m_dout = nv >> 8; m_s1 = m_s1 | 4; end
                    end
                    4: m_s1 = nv & 'h000E;
                    6: m_s2 = nv & 'h0006;
                    8: begin
                        c = (nv & 'h1F00) | (m_c1 & 'h1000);
                        m_c1 = c;
                        if (m_ok(c, m_tmr)) begin m_rld = m_tmr; m_run = 1; end
                        else m_run = 0;
                    end
                    10: m_c2 = nv;
                    12: begin m_m1 = nv & 255; m_m2 = nv >> 8; end
                    14: begin m_wc = nv & 255; m_sw = nv >> 8; end
                    16: m_tmr = nv & 1023;
                    default: ;
                endcase
            end else if (tick_en && m_run == 1) begin
                c = m_rld & 1023;
                if (c > 1) m_rld = (m_rld & 'hFC00) | (c - 1);
                else begin
                    m_s1 = m_s1 | 8;
                    m_to = m_to + 1;
                    if (m_to == 2) begin
                        m_s2 = m_s2 | 6;
                        m_to = 0;
                        if (!strap_spkr_hi && !no_reboot) begin
                            m_rld = 0; m_run = 0; m_rst = 1;
                        end
                    end
                    if (m_rst == 0) begin
                        m_smi = smi_enable ? 1 : 0;
                        m_rld = m_tmr;
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison of the pulse and flag outputs
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check("R6 smi_req", int'(smi_req), m_smi);
            check("R5 reset_req", int'(reset_req), m_rst);
            check("R7 status_irq", int'(status_irq), (m_s1 >> 2) & 1);
        end
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_wr(input int a, input bit h, input int d, input bit tk = 1'b0);
        @(negedge clk);
        bus_addr = a[4:0]; bus_half = h; bus_wdata = d[15:0]; bus_wr = 1'b1; tick_en = tk;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic rd(input int a, input bit h, input string tag);
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0; bus_addr = a[4:0]; bus_half = h;
        #1;
        check(tag, int'(bus_rdata), m_read(a, h));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 18; a += 2) rd(a, 1'b1, "R1");
        rd(10, 1'b1, "R1"); check("R1 ctl2", int'(bus_rdata), 'h0008);
        rd(16, 1'b1, "R1"); check("R1 timer", int'(bus_rdata), 'h0004);
        rd(15, 1'b0, "R1"); check("R1 swirq", int'(bus_rdata), 'h03);
        ticks(3);
        rd(0, 1'b1, "R1 stopped");

        // R3/R4/R6/R5 first and second expiry with reboot allowed
        smi_enable = 1'b1;
        do_wr(0, 1'b1, 'h1234);
        rd(0, 1'b1, "R3"); check("R3 reload", int'(bus_rdata), 4);
        ticks(3);
        rd(0, 1'b1, "R4"); check("R4 count", int'(bus_rdata), 1);
        ticks(1);
        rd(4, 1'b1, "R4"); rd(0, 1'b1, "R6");
        ticks(4);
        rd(0, 1'b1, "R5"); check("R5 halted", int'(bus_rdata), 0);
        rd(6, 1'b1, "R5");
        ticks(2);
        rd(0, 1'b1, "R5");

        // R6 reboot blocked by no_reboot, then by strap
        no_reboot = 1'b1;
        do_wr(0, 1'b1, 0);
        ticks(8);
        rd(0, 1'b1, "R6");
        smi_enable = 1'b0;
        ticks(4);
        no_reboot = 1'b0; strap_spkr_hi = 1'b1;
        ticks(4);
        rd(0, 1'b1, "R6"); rd(6, 1'b1, "R5");
        strap_spkr_hi = 1'b0;
        do_wr(0, 1'b1, 0);   // R3 clears the record
        ticks(4);
        rd(4, 1'b1, "R3");

        // R2 timer values 1 and 0
        do_wr(16, 1'b1, 'hFC01);
        rd(16, 1'b1, "R2");
        do_wr(8, 1'b1, 0);
        do_wr(0, 1'b1, 'h0155);
        ticks(3);
        rd(0, 1'b1, "R2"); check("R2 stored", int'(bus_rdata), 'h0155);
        do_wr(16, 1'b1, 0);
        do_wr(0, 1'b1, 'h2222);
        ticks(2);
        rd(0, 1'b1, "R2");

        // R8 halt, mask and lock
        smi_enable = 1'b1;
        do_wr(16, 1'b1, 6);
        do_wr(8, 1'b1, 0);
        ticks(2);
        do_wr(8, 1'b1, 'h08FF);
        ticks(3);
        rd(0, 1'b1, "R8"); rd(8, 1'b1, "R8");
        do_wr(8, 1'b1, 'h10FF);
        do_wr(8, 1'b1, 0);
        rd(8, 1'b1, "R8"); check("R8 lock", int'(bus_rdata), 'h1000);
        ticks(2);

        // R11 tick together with a write
        do_wr(12, 1'b0, 'h5A, 1'b1);
        rd(0, 1'b1, "R11"); rd(12, 1'b1, "R11");

        // R7 data bytes
        smi_enable = 1'b0;
        do_wr(2, 1'b0, 'hA5);
        do_wr(3, 1'b0, 'h3C);
        rd(2, 1'b1, "R7"); rd(4, 1'b1, "R7");

        // R9 status masks
        do_wr(4, 1'b1, 'hFFFF); rd(4, 1'b1, "R9");
        do_wr(6, 1'b1, 'hFFFF); rd(6, 1'b1, "R9");
        check("R9 sts2", int'(bus_rdata), 'h0006);
        do_wr(4, 1'b1, 0); rd(4, 1'b1, "R9");

        // R10 lanes, odd 2-byte access, unmapped addresses
        do_wr(13, 1'b0, 'h77);
        do_wr(15, 1'b0, 'h11);
        rd(12, 1'b1, "R10"); rd(13, 1'b0, "R10"); rd(15, 1'b0, "R10");
        check("R10 lane", int'(bus_rdata), 'h11);
        do_wr(5, 1'b1, 'hFFFF); rd(4, 1'b1, "R10"); rd(5, 1'b1, "R10");
        do_wr(18, 1'b1, 'hFFFF); rd(18, 1'b1, "R10"); rd(30, 1'b1, "R10");
        do_wr(10, 1'b1, 'hBEEF); rd(11, 1'b0, "R10");

        repeat (3) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule